// File: doc/BRIEF.md
# Servo Move Execute Driver

This block is a shared helper sequencer that carries out one servo move for whichever control sequence asks for it. A requester writes a move identifier onto the move-ID input and pulses the flag-set input, which raises the execute flag. When the driver sees the raised flag it copies the move identifier into its target address register. It then counts down a programmable settle delay and fires a single-cycle move trigger. After that it waits for the motion stage to report move-done.

When move-done arrives the driver lowers the execute flag and goes back to idle. The lowered flag is the only completion indication the requester gets. There is no separate done or status output, so a requester watches the flag and waits for it to fall. While the flag is high the driver is busy, and further flag-set pulses have no effect. The request side is a plain level handshake on the flag rather than a valid/ready stream. Move-ID and settle delay are sampled once, at load time, so the requester need not hold them afterwards.

Top module: `srv_exec_drv`

## Requirements
- R1: After reset the execute flag, the move trigger and the target address are all 0.
- R2: A flag-set pulse while the driver is idle raises the execute flag on the next clock edge. The flag then stays high until the driver lowers it on move-done.
- R3: The target address takes the move-ID value on the second clock edge after the flag is raised. It holds that value through the move and after completion until the next request loads it, even if move-ID changes.
- R4: The move trigger is high for exactly one clock cycle. It first reads high after the edge that is D+3 edges after the edge capturing flag-set, where D is the settle delay sampled at load.
- R5: Each request produces exactly one trigger pulse. No trigger occurs while the driver is waiting for move-done, or while it is idle.
- R6: Move-done is ignored unless the driver is waiting for it after the trigger. A move-done pulse earlier in the request leaves the flag high and does not stop the trigger.
- R7: Move-done while the driver is waiting lowers the execute flag on that edge, and the driver returns to idle. No new move starts afterwards without a new flag-set.
- R8: A flag-set pulse while the driver is busy has no effect. No second move follows the completion of the current one.
- R9: If flag-set and an accepted move-done occur on the same edge, the clear takes effect: the flag is low afterwards and no new move starts.
- R10: Changes to the settle delay input after load do not alter the trigger timing of the current move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set_i | input | 1 | Requester pulse that raises the execute flag |
| move_id_i | input | ID_W | Requested move identifier, sampled at load |
| settle_dly_i | input | DLY_W | Settle delay in clock cycles, sampled at load |
| move_done_i | input | 1 | Motion stage reports the move finished |
| exec_flag_o | output | 1 | Shared execute flag; falls to signal completion |
| tgt_addr_o | output | ID_W | Target address loaded from move-ID |
| trig_o | output | 1 | Single-cycle move trigger |

## Verification
The properties assume that move-done is the only cause of a clear, and that the requester never expects completion from anything other than a falling flag. The stimulus therefore pulses move-done only as a single-cycle event. Each random request picks a move identifier, a settle delay of up to 31 cycles and a done latency. Extra flag-set and move-done pulses are injected only at points where the requirements say they must be ignored. The same-edge set and clear case, and a zero settle delay, are driven as directed cases.

// File: rtl/srv_drv_pkg.sv
package srv_drv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_FIRE,
    ST_AWAIT
  } srv_st_e;
endpackage

// File: rtl/srv_flag_reg.sv
module srv_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // clear has priority over set (R9)
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/srv_settle_cnt.sv
module srv_settle_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load_i)                 cnt_q <= dly_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/srv_seq.sv
module srv_seq
  import srv_drv_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_i,
  input  logic            zero_i,
  input  logic            done_i,
  input  logic [ID_W-1:0] id_i,
  output logic            load_o,
  output logic            settle_o,
  output logic            fire_o,
  output logic            clr_o,
  output logic            await_o,
  output logic [ID_W-1:0] tgt_o
);
  srv_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (flag_i) st_d = ST_LOAD;
      ST_LOAD:   st_d = ST_SETTLE;
      ST_SETTLE: if (zero_i) st_d = ST_FIRE;
      ST_FIRE:   st_d = ST_AWAIT;
      ST_AWAIT:  if (done_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // target register: written only in the load state (R3)
  always_ff @(posedge clk) begin
    if (!rst_n)      tgt_o <= '0;
    else if (load_o) tgt_o <= id_i;
  end

  assign load_o   = (st_q == ST_LOAD);
  assign settle_o = (st_q == ST_SETTLE);
  assign fire_o   = (st_q == ST_FIRE);
  assign await_o  = (st_q == ST_AWAIT);
  assign clr_o    = await_o && done_i;
endmodule

// File: rtl/srv_exec_drv.sv
module srv_exec_drv #(
  parameter int ID_W  = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_set_i,
  input  logic [ID_W-1:0]  move_id_i,
  input  logic [DLY_W-1:0] settle_dly_i,
  input  logic             move_done_i,
  output logic             exec_flag_o,
  output logic [ID_W-1:0]  tgt_addr_o,
  output logic             trig_o
);
  logic load_w, settle_w, zero_w, clr_w, await_w;

  srv_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set_i), .clr_i(clr_w),
    .flag_o(exec_flag_o)
  );

  srv_settle_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .dly_i(settle_dly_i),
    .run_i(settle_w), .zero_o(zero_w)
  );

  srv_seq #(.ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .flag_i(exec_flag_o), .zero_i(zero_w),
    .done_i(move_done_i), .id_i(move_id_i), .load_o(load_w),
    .settle_o(settle_w), .fire_o(trig_o), .clr_o(clr_w),
    .await_o(await_w), .tgt_o(tgt_addr_o)
  );
endmodule

// File: rtl/srv_exec_drv_chk.sv
module srv_exec_drv_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flag_set_i,
  input logic            move_done_i,
  input logic            exec_flag_o,
  input logic [ID_W-1:0] tgt_addr_o,
  input logic            trig_o,
  input logic            await_i
);
  // R4
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R5
  trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> exec_flag_o);

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_flag_o && !move_done_i) |=> exec_flag_o);

  // R6
  early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_flag_o && !await_i) |=> exec_flag_o);

  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exec_flag_o) |-> $past(move_done_i));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (await_i && move_done_i && flag_set_i) |=> !exec_flag_o);

  // R3
  tgt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgt_addr_o) |-> $past(exec_flag_o));
endmodule

bind srv_exec_drv srv_exec_drv_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flag_set_i(flag_set_i),
  .move_done_i(move_done_i), .exec_flag_o(exec_flag_o),
  .tgt_addr_o(tgt_addr_o), .trig_o(trig_o), .await_i(await_w)
);

// File: tb/srv_exec_drv_tb_top.sv
module srv_exec_drv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W  = 8;
  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flag_set = 1'b0;
  logic done = 1'b0;
  logic [ID_W-1:0]  mid = '0;
  logic [DLY_W-1:0] dly = '0;
  logic flag, trig;
  logic [ID_W-1:0] tgt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srv_exec_drv #(.ID_W(ID_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flag_set_i(flag_set), .move_id_i(mid),
    .settle_dly_i(dly), .move_done_i(done), .exec_flag_o(flag),
    .tgt_addr_o(tgt), .trig_o(trig)
  );

  function automatic int exp_latency(input int d);
    return d + 3;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_move(input logic [ID_W-1:0] id, input logic [DLY_W-1:0] d,
                          input int done_lat, input bit poke, input bit early,
                          input bit coset);
    int k;
    @(negedge clk);
    flag_set = 1'b1; mid = id; dly = d;
    @(posedge clk);
    @(negedge clk);
    flag_set = 1'b0;
    chk(flag === 1'b1, "R2 flag raised", longint'(flag), 1);
    k = 0;
    while (trig !== 1'b1 && k < 400) begin
      @(negedge clk);
      k++;
      done = 1'b0; flag_set = 1'b0;
      if (k == 2) begin
        mid = ~id; dly = d ^ 8'h5A;
        if (poke)  flag_set = 1'b1;
        if (early) done = 1'b1;
      end
    end
    done = 1'b0; flag_set = 1'b0;
    chk(k == exp_latency(int'(d)), "R4 R10 trigger latency", k, exp_latency(int'(d)));
    chk(tgt == id, "R3 target loaded", longint'(tgt), longint'(id));
    chk(flag === 1'b1, "R6 flag still high at trigger", longint'(flag), 1);
    @(negedge clk);
    chk(trig === 1'b0, "R4 single-cycle trigger", longint'(trig), 0);
    repeat (done_lat) begin
      @(negedge clk);
      chk(trig === 1'b0 && flag === 1'b1, "R5 wait for done",
          longint'({trig, flag}), 1);
    end
    done = 1'b1;
    if (coset) flag_set = 1'b1;
    @(negedge clk);
    done = 1'b0; flag_set = 1'b0;
    chk(flag === 1'b0, coset ? "R9 clear wins" : "R7 flag cleared", longint'(flag), 0);
    chk(tgt == id, "R3 target held", longint'(tgt), longint'(id));
    repeat (3) begin
      @(negedge clk);
      chk(flag === 1'b0 && trig === 1'b0, "R8 R9 idle after completion",
          longint'({trig, flag}), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(flag === 1'b0, "R1 flag reset", longint'(flag), 0);
    chk(trig === 1'b0, "R1 trig reset", longint'(trig), 0);
    chk(tgt == '0, "R1 target reset", longint'(tgt), 0);

    // directed: zero delay, then maximum delay, then busy poke and early done
    run_move(8'hA5, 8'd0, 0, 1'b0, 1'b0, 1'b0);
    run_move(8'h3C, 8'd255, 2, 1'b0, 1'b0, 1'b0);
    run_move(8'h01, 8'd4, 1, 1'b1, 1'b1, 1'b0);
    // directed: set coincident with accepted done (R9)
    run_move(8'h7E, 8'd2, 3, 1'b0, 1'b0, 1'b1);

    for (int n = 0; n < 40; n++) begin
      run_move(8'($urandom), 8'($urandom_range(0, 31)),
               int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule